// File: doc/BRIEF.md
# Load-Hold-Run Event Timer

This block is a one-shot countdown timer with a free-running time base beside it. Software writes a period value, then steers the countdown with operation codes written to a control register. The load code copies the period into the counter. The run code starts the countdown. The hold code freezes the count. When a running countdown reaches zero, the counter stops there and a pending flag is raised. The counter stays at zero until software loads it again. The current count can be read at any time, so software can work out the time elapsed since the countdown started: the period minus the count, times one tick.

The pending flag is set whether or not the interrupt is enabled. The interrupt pin is the pending flag gated by a mask bit. Software clears the flag by writing a one to the acknowledge register. A second counter increments on every clock and wraps around. A control field selects the tick rate: either every clock, or one tick per `SLOW_DIV` clocks. The register port is a plain write strobe with an address and data, plus a combinational read port. There is no handshake.

Register map (3-bit address): 0 period (read/write), 1 control (read/write), 2 countdown value (read-only), 3 mask (bit 0), 4 raw pending (bit 0, read-only), 5 masked pending (bit 0, read-only), 6 acknowledge (write-only, reads 0), 7 time base (read-only). Control bits [1:0] carry the operation: 0 = hold, 1 = load, 2 = run, 3 = treated as hold. Control bit 2 selects the rate: 0 = every clock, 1 = every `SLOW_DIV` clocks.

Top module: `evt_timer`

## Requirements
- R1: After reset, the period reads 2. Control, countdown, mask, raw pending, masked pending, the irq pin and the time base all read 0.
- R2: A period write with a value below 2 stores 2. Any other value is stored exactly, up to the all-ones maximum.
- R3: While the operation is load, each clock edge copies the current period into the countdown. A load written at edge e becomes visible in the countdown after edge e+1, and the countdown follows later period writes one edge behind.
- R4: While the operation is hold (code 0 or 3), the countdown does not change.
- R5: At rate 0 during run, the countdown drops by one on every edge. If the run write lands on the same edge as the load copy, the count reaches 0 exactly N edges later for a period N. It then stays at 0.
- R6: At rate 1 during run, the countdown drops by one every `SLOW_DIV` edges. Any control write restarts that spacing, so the first decrement comes `SLOW_DIV` edges after the write.
- R7: The raw pending bit sets on the edge at which the running countdown steps from 1 to 0, whatever the mask bit is.
- R8: The irq pin and the masked-pending register both equal raw pending AND the mask bit.
- R9: Writing an acknowledge value with bit 0 set clears raw pending. Writing one with bit 0 clear leaves it unchanged.
- R10: If an acknowledge and an expiry land on the same edge, raw pending stays set.
- R11: The time base increments by one on every edge after reset and wraps from all-ones to zero.
- R12: Writes to the countdown and time-base addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sweeps every legal period of an 8-bit build and compares the count against the period minus the elapsed edges on every cycle. A design that is off by one edge in the load or run path, or that wraps below zero instead of stopping, fails that sweep at once. It lands an acknowledge exactly on the expiry edge, where a design that let the acknowledge win would lose the interrupt. It also writes periods of 0 and 1, where a design without the floor would never expire or would expire at once. The slow rate, hold across a run, masked expiry and time-base wraparound are each checked against arithmetic done in the bench.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_PERIOD = 3'd0;
  localparam logic [AW-1:0] A_CTRL   = 3'd1;
  localparam logic [AW-1:0] A_COUNT  = 3'd2;
  localparam logic [AW-1:0] A_MASK   = 3'd3;
  localparam logic [AW-1:0] A_RAW    = 3'd4;
  localparam logic [AW-1:0] A_MASKED = 3'd5;
  localparam logic [AW-1:0] A_ACK    = 3'd6;
  localparam logic [AW-1:0] A_TIME   = 3'd7;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_ALT  = 2'd3
  } op_e;
endpackage

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slow,
  output logic tick
);
  generate
    if (SLOW_DIV <= 1) begin : g_flat
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(SLOW_DIV);
      localparam logic [PW-1:0] LAST = PW'(SLOW_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (clr)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end

      assign tick = !slow || (pre_q == LAST);

      // R6
      slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && tick) |=> !(slow && tick));
    end
  endgenerate
endmodule

// File: rtl/evt_downcount.sv
module evt_downcount
  import evt_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op,
  input  logic          tick,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  logic running;
  logic loading;

  assign running = (op == OP_RUN);
  assign loading = (op == OP_LOAD);
  assign expire  = running && tick && (cnt == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (loading)                    cnt <= period;
    else if (running && tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !loading) |=> $stable(cnt));

  // R5
  run_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (cnt <= $past(cnt)));

  // R7
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0));
endmodule

// File: rtl/evt_pending.sv
module evt_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (ack)    pending <= 1'b0;
  end

  // R10
  expiry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !pending);
endmodule

// File: rtl/evt_timebase.sv
module evt_timebase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  // R11
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (now == $past(now) + 1'b1));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [DW-1:0] FLOOR = DW'(2);

  logic [DW-1:0] period_q;
  logic [1:0]    op_q;
  logic          slow_q;
  logic          mask_q;
  logic          ctrl_wr;
  logic          ack_wr;
  logic          tick;
  logic          expire;
  logic          pending;
  logic [DW-1:0] cnt;
  logic [DW-1:0] now;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign ack_wr  = wr_en && (wr_addr == A_ACK) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= FLOOR;
      op_q     <= OP_HOLD;
      slow_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: period_q <= (wr_data < FLOOR) ? FLOOR : wr_data;
        A_CTRL: begin
          op_q   <= wr_data[1:0];
          slow_q <= wr_data[2];
        end
        A_MASK:   mask_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  evt_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .slow(slow_q), .tick(tick)
  );

  evt_downcount #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op(op_q), .tick(tick), .period(period_q),
    .cnt(cnt), .expire(expire)
  );

  evt_pending u_pend (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack_wr), .pending(pending)
  );

  evt_timebase #(.DW(DW)) u_time (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  assign irq = pending && mask_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_PERIOD: rd_data = period_q;
      A_CTRL:   rd_data = {{(DW-3){1'b0}}, slow_q, op_q};
      A_COUNT:  rd_data = cnt;
      A_MASK:   rd_data = {{(DW-1){1'b0}}, mask_q};
      A_RAW:    rd_data = {{(DW-1){1'b0}}, pending};
      A_MASKED: rd_data = {{(DW-1){1'b0}}, irq};
      default:  rd_data = (rd_addr == A_TIME) ? now : '0;
    endcase
  end

  // R2
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_q >= FLOOR);

  // R8
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q) |-> !irq);
endmodule

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;
  localparam int DW = 8;
  localparam int SD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer #(.DW(DW), .SLOW_DIV(SD)) i_evt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[2:0];
    #0.2;
    v = int'(rd_data);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[DW-1:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, t0, c0, pend_exp;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 period", v, 2);
    rd(1, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 mask", v, 0);
    rd(4, v); chk("R1 raw", v, 0);
    rd(5, v); chk("R1 masked", v, 0);
    rd(7, v); chk("R1 time", v, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 period floor
    wr(0, 0);   rd(0, v); chk("R2 zero", v, 2);
    wr(0, 1);   rd(0, v); chk("R2 one", v, 2);
    wr(0, 3);   rd(0, v); chk("R2 three", v, 3);
    wr(0, 255); rd(0, v); chk("R2 max", v, 255);

    // R3 load follows the period one edge behind
    wr(0, 40);
    wr(1, 1);
    rd(2, v); chk("R3 not yet", v, 0);
    step(1);
    rd(2, v); chk("R3 loaded", v, 40);
    wr(0, 77);
    rd(2, v); chk("R3 lag", v, 40);
    step(1);
    rd(2, v); chk("R3 follow", v, 77);

    // R5 R7 R8 sweep of every legal period
    for (int d = 2; d < 256; d++) begin
      wr(6, 1);
      wr(3, d & 1);
      wr(0, d);
      wr(1, 1);
      wr(1, 2);
      for (int k = 0; k <= d + 2; k++) begin
        pend_exp = (k >= d) ? 1 : 0;
        rd(2, v); chk("R5 count", v, (k < d) ? d - k : 0);
        rd(4, v); chk("R7 raw", v, pend_exp);
        rd(5, v); chk("R8 masked reg", v, pend_exp & (d & 1));
        chk("R8 irq", int'(irq), pend_exp & (d & 1));
        step(1);
      end
    end

    // R9 acknowledge behaviour (pending is set here)
    wr(6, 0); rd(4, v); chk("R9 ack zero keeps", v, 1);
    wr(6, 1); rd(4, v); chk("R9 ack clears", v, 0);

    // R10 acknowledge on the expiry edge
    wr(0, 6); wr(1, 1); wr(1, 2);
    step(5);
    rd(2, v); chk("R10 setup", v, 1);
    wr(6, 1);
    rd(2, v); chk("R10 count zero", v, 0);
    rd(4, v); chk("R10 expiry wins", v, 1);
    wr(6, 1);

    // R4 hold during a run, codes 0 and 3
    wr(0, 50); wr(1, 1); wr(1, 2);
    step(3);
    rd(2, c0);
    wr(1, 0);
    step(5);
    rd(2, v); chk("R4 hold", v, c0 - 1);
    wr(1, 2);
    step(2);
    rd(2, v); chk("R4 resume", v, c0 - 3);
    wr(1, 3);
    rd(2, c0);
    step(4);
    rd(2, v); chk("R4 code3 hold", v, c0);

    // R6 slow rate
    for (int d = 2; d <= 5; d++) begin
      wr(6, 1);
      wr(0, d);
      wr(1, 1);
      wr(1, 6);
      for (int j = 0; j <= SD * d + 3; j++) begin
        rd(2, v); chk("R6 slow count", v, (j / SD < d) ? d - j / SD : 0);
        rd(4, v); chk("R6 slow expiry", v, (j >= SD * d) ? 1 : 0);
        step(1);
      end
    end

    // R12 read-only addresses
    wr(6, 1);
    wr(0, 30); wr(1, 1); wr(1, 0);
    wr(2, 9);
    rd(2, v); chk("R12 count write", v, 30);
    rd(7, t0);
    wr(7, 0);
    rd(7, v); chk("R12 time write", v, (t0 + 1) & 255);

    // R11 time base steps and wraps
    rd(7, t0);
    step(300);
    rd(7, v); chk("R11 wrap", v, (t0 + 300) & 255);
    step(1);
    rd(7, v); chk("R11 step", v, (t0 + 301) & 255);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule